// File: doc/BRIEF.md
# Layer-2 Dual-Hash Bucket Lookup

This unit searches a layer-2 forwarding table for a 60-bit key. The key is a 48-bit MAC address (key bits 59:12, first octet in bits 59:52) followed by a 12-bit VLAN/filtering ID (key bits 11:0). The table is split into two halves. Each half picks one of two 11-bit hash functions. A lookup computes one bucket index per half and reads the four ways of both buckets in parallel. It then reports whether an entry matched, which half and way it sits in, its table address and its decoded fields.

A host write port fills entry slots by table address. Each entry is three 32-bit words. The result appears two clock edges after the request. The parameter `HALF_BITS` sets how many hash bits index each half. At 11 the unit covers 4096 buckets, which is 16384 entries. The default is smaller.

Top module: `l2_hash_lookup`

## Requirements
- R1: Hash algorithm 0 XORs the 11-bit key slices at bit offsets 0, 11, 22, 33 and 44 with the zero-extended 5-bit slice at offset 55.
- R2: Hash algorithm 1 XORs the same six slices after rotating two of them. The slice at offset 11 becomes {low 5 bits, high 6 bits}. The slice at offset 33 becomes {low 6 bits, high 5 bits}.
- R3: `alg_sel[0]` picks the hash for half 0 and `alg_sel[1]` picks it for half 1. A value of 1 selects algorithm 1. Both are sampled with the request.
- R4: A half-0 bucket is the low `HALF_BITS` of its hash. A half-1 bucket is that value plus 2^`HALF_BITS`. The entry address is {bucket, way[1:0]}.
- R5: A hit requires three things: the slot has been written since reset, word 2 bit 31 is set, and the stored MAC ({word 0, word 1[31:16]}) equals the key. The VLAN ID must also match. For unicast entries it is read from word 2 bits 11:0, and for multicast entries from word 1 bits 11:0.
- R6: When several ways match, half 0 beats half 1. Within a half, the lowest-numbered way wins.
- R7: For a unicast hit (MAC first-octet bit 0 clear), the unit reports the following fields and sets `rsp_pmask` to zero:
  - `rsp_dest` from word 2 bits 29:20
  - `rsp_trunk` from bit 30
  - `rsp_static` from bit 14
  - `rsp_age` from bits 18:17
- R8: A multicast hit reports `rsp_mcast`=1 and `rsp_pmask` from word 2 bits 17:6. The destination, trunk, static and age outputs are zero.
- R9: `rsp_valid` is a one-cycle pulse on the second rising edge after the request is sampled. On a miss, every result field, including the address, is zero.
- R10: A write sampled on the same edge as a lookup request is seen by that lookup. A write sampled one edge later is not.
- R11: After reset, `rsp_valid` and `rsp_hit` are low and no slot can hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alg_sel | input | 2 | Hash choice per half |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | HALF_BITS+3 | Entry address {bucket, way} |
| wr_w0 | input | 32 | Entry word 0 |
| wr_w1 | input | 32 | Entry word 1 |
| wr_w2 | input | 32 | Entry word 2 |
| req_valid | input | 1 | Lookup request strobe |
| req_key | input | 60 | Lookup key {MAC, VID} |
| rsp_valid | output | 1 | Result valid pulse |
| rsp_hit | output | 1 | Matching entry found |
| rsp_half | output | 1 | Half holding the hit |
| rsp_way | output | 2 | Way holding the hit |
| rsp_addr | output | HALF_BITS+3 | Entry address of the hit |
| rsp_mcast | output | 1 | Hit entry is multicast |
| rsp_dest | output | 10 | Unicast destination |
| rsp_trunk | output | 1 | Unicast trunk flag |
| rsp_static | output | 1 | Unicast static flag |
| rsp_age | output | 2 | Unicast age |
| rsp_pmask | output | 12 | Multicast portmask index |

## Verification
A host write and a lookup can share a cycle, and they can also target the very bucket being read. The bench provokes this in two ways. First, it drives a write and a lookup request for the same key on one clock edge and expects a hit. Second, it delays the write by one edge and expects a miss, followed by a hit on a repeated lookup. This pins down exactly which edge separates an entry's old and new contents as seen by the read stage.

// File: rtl/l2h_pkg.sv
package l2h_pkg;
   localparam int KEY_W  = 60;
   localparam int HASH_W = 11;
   localparam int WAYS   = 4;
   localparam int WAY_W  = 2;
   localparam int VID_W  = 12;
   localparam int MAC_W  = 48;

   typedef struct packed {
      logic [31:0] w2;
      logic [31:0] w1;
      logic [31:0] w0;
   } entry_t;

   typedef struct packed {
      logic       hit;
      logic       half;
      logic [1:0] way;
      logic       mcast;
      logic [9:0] dest;
      logic       trunk;
      logic       stat;
      logic [1:0] age;
      logic [11:0] pmask;
   } result_t;

   function automatic logic [MAC_W-1:0] entry_mac(entry_t e);
      return {e.w0, e.w1[31:16]};
   endfunction

   function automatic logic entry_is_mc(entry_t e);
      return e.w0[24];
   endfunction

   function automatic logic [VID_W-1:0] entry_vid(entry_t e);
      return e.w0[24] ? e.w1[11:0] : e.w2[11:0];
   endfunction
endpackage

// File: rtl/l2h_hash.sv
module l2h_hash #(
   parameter int ALG = 0
) (
   input  logic [l2h_pkg::KEY_W-1:0]  key,
   output logic [l2h_pkg::HASH_W-1:0] hash
);
   import l2h_pkg::*;

   logic [HASH_W-1:0] s0, s1, s2, s3, s4, s5;

   assign s0 = key[10:0];
   assign s1 = key[21:11];
   assign s2 = key[32:22];
   assign s3 = key[43:33];
   assign s4 = key[54:44];
   assign s5 = {6'd0, key[59:55]};

   generate
      if (ALG == 0) begin : g_plain
         assign hash = s0 ^ s1 ^ s2 ^ s3 ^ s4 ^ s5;
      end else if (ALG == 1) begin : g_rot
         logic [HASH_W-1:0] r1, r3;
         assign r1   = {s1[4:0], s1[10:5]};
         assign r3   = {s3[5:0], s3[10:6]};
         assign hash = s0 ^ r1 ^ s2 ^ r3 ^ s4 ^ s5;
      end else begin : g_bad
         $error("l2h_hash: ALG must be 0 or 1");
      end
   endgenerate

   // R1 R2: an all-zero key folds to bucket zero under either algorithm
   always_comb begin
      if (key == '0) begin
         p_zero_key_r1: assert (hash == '0);
      end
   end
endmodule

// File: rtl/l2h_way_bank.sv
module l2h_way_bank #(
   parameter int BKT_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [BKT_W-1:0]      wr_bkt,
   input  l2h_pkg::entry_t       wr_entry,
   input  logic [BKT_W-1:0]      rd_bkt_a,
   input  logic [BKT_W-1:0]      rd_bkt_b,
   output l2h_pkg::entry_t       rd_a,
   output l2h_pkg::entry_t       rd_b
);
   import l2h_pkg::*;

   localparam int DEPTH = 1 << BKT_W;

   entry_t           mem [DEPTH];
   logic [DEPTH-1:0] written;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_bkt] <= wr_entry;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     written <= '0;
      else if (wr_en) written[wr_bkt] <= 1'b1;
   end

   assign rd_a = written[rd_bkt_a] ? mem[rd_bkt_a] : '0;
   assign rd_b = written[rd_bkt_b] ? mem[rd_bkt_b] : '0;

   // R10: a write is readable on the very next cycle
   p_write_visible_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_bkt_a != $past(wr_bkt)) || (rd_a == $past(wr_entry)));
endmodule

// File: rtl/l2h_match.sv
module l2h_match (
   input  logic [l2h_pkg::KEY_W-1:0]                key,
   input  l2h_pkg::entry_t [l2h_pkg::WAYS-1:0]      ent_h0,
   input  l2h_pkg::entry_t [l2h_pkg::WAYS-1:0]      ent_h1,
   output l2h_pkg::result_t                          res
);
   import l2h_pkg::*;

   localparam int SLOTS = 2 * WAYS;

   logic [SLOTS-1:0] m;
   logic [MAC_W-1:0] key_mac;
   logic [VID_W-1:0] key_vid;

   assign key_mac = key[KEY_W-1:VID_W];
   assign key_vid = key[VID_W-1:0];

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign m[w]        = ent_h0[w].w2[31] && (entry_mac(ent_h0[w]) == key_mac)
                              && (entry_vid(ent_h0[w]) == key_vid);
         assign m[WAYS + w] = ent_h1[w].w2[31] && (entry_mac(ent_h1[w]) == key_mac)
                              && (entry_vid(ent_h1[w]) == key_vid);
      end
   endgenerate

   logic [2:0] sel;
   entry_t     e;

   always_comb begin
      sel = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (m[i]) sel = i[2:0];
      end
      e = sel[2] ? ent_h1[sel[1:0]] : ent_h0[sel[1:0]];
      res = '0;
      if (|m) begin
         res.hit   = 1'b1;
         res.half  = sel[2];
         res.way   = sel[1:0];
         res.mcast = entry_is_mc(e);
         if (entry_is_mc(e)) begin
            res.pmask = e.w2[17:6];
         end else begin
            res.dest  = e.w2[29:20];
            res.trunk = e.w2[30];
            res.stat  = e.w2[14];
            res.age   = e.w2[18:17];
         end
      end
   end
endmodule

// File: rtl/l2_hash_lookup.sv
module l2_hash_lookup #(
   parameter int HALF_BITS = 7
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             alg_sel,
   input  logic                   wr_en,
   input  logic [HALF_BITS+2:0]   wr_addr,
   input  logic [31:0]            wr_w0,
   input  logic [31:0]            wr_w1,
   input  logic [31:0]            wr_w2,
   input  logic                   req_valid,
   input  logic [59:0]            req_key,
   output logic                   rsp_valid,
   output logic                   rsp_hit,
   output logic                   rsp_half,
   output logic [1:0]             rsp_way,
   output logic [HALF_BITS+2:0]   rsp_addr,
   output logic                   rsp_mcast,
   output logic [9:0]             rsp_dest,
   output logic                   rsp_trunk,
   output logic                   rsp_static,
   output logic [1:0]             rsp_age,
   output logic [11:0]            rsp_pmask
);
   import l2h_pkg::*;

   localparam int BKT_W  = HALF_BITS + 1;
   localparam int ADDR_W = BKT_W + WAY_W;

   generate
      if (HALF_BITS < 1 || HALF_BITS > HASH_W) begin : g_bad_cfg
         $error("l2_hash_lookup: HALF_BITS out of range");
      end
   endgenerate

   // ---- hash units, one per algorithm, shared by both halves
   logic [HASH_W-1:0] hraw [2];

   generate
      for (genvar a = 0; a < 2; a++) begin : g_alg
         l2h_hash #(.ALG(a)) u_hash (.key(req_key), .hash(hraw[a]));
      end
   endgenerate

   logic [HASH_W-1:0] h0, h1;
   logic [BKT_W-1:0]  bkt0, bkt1;

   assign h0   = alg_sel[0] ? hraw[1] : hraw[0];
   assign h1   = alg_sel[1] ? hraw[1] : hraw[0];
   assign bkt0 = {1'b0, h0[HALF_BITS-1:0]};
   assign bkt1 = {1'b1, h1[HALF_BITS-1:0]};

   // ---- stage 1: registered bucket indices
   logic              s1_valid;
   logic [KEY_W-1:0]  s1_key;
   logic [BKT_W-1:0]  s1_bkt0, s1_bkt1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_key   <= '0;
         s1_bkt0  <= '0;
         s1_bkt1  <= '0;
      end else begin
         s1_valid <= req_valid;
         if (req_valid) begin
            s1_key  <= req_key;
            s1_bkt0 <= bkt0;
            s1_bkt1 <= bkt1;
         end
      end
   end

   // ---- way banks
   entry_t [WAYS-1:0] ent_h0, ent_h1;
   entry_t            wr_entry;

   assign wr_entry = '{w2: wr_w2, w1: wr_w1, w0: wr_w0};

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_bank
         l2h_way_bank #(.BKT_W(BKT_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_addr[WAY_W-1:0] == w[WAY_W-1:0])),
            .wr_bkt   (wr_addr[ADDR_W-1:WAY_W]),
            .wr_entry (wr_entry),
            .rd_bkt_a (s1_bkt0),
            .rd_bkt_b (s1_bkt1),
            .rd_a     (ent_h0[w]),
            .rd_b     (ent_h1[w])
         );
      end
   endgenerate

   // ---- compare, select, decode
   result_t res;

   l2h_match u_match (
      .key    (s1_key),
      .ent_h0 (ent_h0),
      .ent_h1 (ent_h1),
      .res    (res)
   );

   // ---- stage 2: registered result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_half   <= 1'b0;
         rsp_way    <= '0;
         rsp_addr   <= '0;
         rsp_mcast  <= 1'b0;
         rsp_dest   <= '0;
         rsp_trunk  <= 1'b0;
         rsp_static <= 1'b0;
         rsp_age    <= '0;
         rsp_pmask  <= '0;
      end else begin
         rsp_valid  <= s1_valid;
         rsp_hit    <= s1_valid & res.hit;
         rsp_half   <= s1_valid & res.half;
         rsp_way    <= s1_valid ? res.way : '0;
         rsp_addr   <= (s1_valid && res.hit) ?
                       {(res.half ? s1_bkt1 : s1_bkt0), res.way} : '0;
         rsp_mcast  <= s1_valid & res.mcast;
         rsp_dest   <= s1_valid ? res.dest : '0;
         rsp_trunk  <= s1_valid & res.trunk;
         rsp_static <= s1_valid & res.stat;
         rsp_age    <= s1_valid ? res.age : '0;
         rsp_pmask  <= s1_valid ? res.pmask : '0;
      end
   end

   // R9: every accepted request yields exactly one result pulse
   p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> rsp_valid);
   p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !rsp_valid);
   p_hit_only_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> rsp_valid);
   // R4: hits in half 1 sit in the upper part of the bucket space
   p_half1_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && rsp_half) |-> rsp_addr[ADDR_W-1]);
   // R7 R8: unicast and multicast field groups never both show up
   p_field_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit && !rsp_mcast) |-> (rsp_pmask == '0));
endmodule

// File: tb/tb_l2_hash_lookup.sv
`timescale 1ns/1ps
module tb_l2_hash_lookup;
   localparam int HB = 7;
   localparam int AW = HB + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    alg_sel = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0]   wr_w0 = '0, wr_w1 = '0, wr_w2 = '0;
   logic          req_valid = 1'b0;
   logic [59:0]   req_key = '0;
   logic          rsp_valid, rsp_hit, rsp_half, rsp_mcast, rsp_trunk, rsp_static;
   logic [1:0]    rsp_way, rsp_age;
   logic [AW-1:0] rsp_addr;
   logic [9:0]    rsp_dest;
   logic [11:0]   rsp_pmask;

   always #2 clk = ~clk;

   l2_hash_lookup #(.HALF_BITS(HB)) dut (
      .clk(clk), .rst_n(rst_n), .alg_sel(alg_sel), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_w0(wr_w0), .wr_w1(wr_w1), .wr_w2(wr_w2), .req_valid(req_valid),
      .req_key(req_key), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_half(rsp_half),
      .rsp_way(rsp_way), .rsp_addr(rsp_addr), .rsp_mcast(rsp_mcast), .rsp_dest(rsp_dest),
      .rsp_trunk(rsp_trunk), .rsp_static(rsp_static), .rsp_age(rsp_age),
      .rsp_pmask(rsp_pmask)
   );

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct packed {
      logic [59:0] key;
      logic [1:0]  alg;
      logic        half;
      logic [1:0]  way;
      logic        mc;
      logic [9:0]  dest;
      logic        trunk;
      logic        stat;
      logic [1:0]  age;
      logic [11:0] pmask;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{60'h001122334455_00A, 2'b00, 1'b0, 2'd0, 1'b0, 10'h155, 1'b0, 1'b1, 2'd2, 12'h000},
      '{60'h02ABCDEF0123_064, 2'b01, 1'b0, 2'd3, 1'b0, 10'h3FF, 1'b1, 1'b0, 2'd1, 12'h000},
      '{60'h01005E0000FB_001, 2'b10, 1'b1, 2'd1, 1'b1, 10'h000, 1'b0, 1'b0, 2'd0, 12'hABC},
      '{60'hDEADBEEF0001_FFF, 2'b11, 1'b1, 2'd2, 1'b0, 10'h001, 1'b0, 1'b1, 2'd3, 12'h000},
      '{60'h333300000016_7FF, 2'b11, 1'b0, 2'd2, 1'b1, 10'h000, 1'b0, 1'b0, 2'd0, 12'h001},
      '{60'hFFFFFFFFFFFF_800, 2'b00, 1'b1, 2'd0, 1'b1, 10'h000, 1'b0, 1'b0, 2'd0, 12'hFFF}
   };

   // R1 R2 from the requirement text
   function automatic logic [10:0] ref_hash(input logic alg, input logic [59:0] k);
      logic [10:0] a, c;
      a = k[21:11];
      c = k[43:33];
      if (alg) begin
         a = {a[4:0], a[10:5]};
         c = {c[5:0], c[10:6]};
      end
      return k[10:0] ^ a ^ k[32:22] ^ c ^ k[54:44] ^ {6'd0, k[59:55]};
   endfunction

   // R3 R4
   function automatic logic [AW-1:0] ref_addr(input logic [1:0] alg, input logic half,
                                              input logic [59:0] k, input logic [1:0] way);
      logic [10:0] h;
      h = ref_hash(alg[half], k);
      return {half, h[HB-1:0], way};
   endfunction

   function automatic logic [95:0] mk_entry(input vec_t v, input logic vbit);
      logic [31:0] w0, w1, w2;
      w0 = v.key[59:28];
      w1 = {v.key[27:12], 4'd0, (v.mc ? v.key[11:0] : 12'd0)};
      if (v.mc) w2 = {vbit, 13'd0, v.pmask, 6'd0};
      else      w2 = {vbit, v.trunk, v.dest, 1'b0, v.age, 2'b00, v.stat, 2'b00, v.key[11:0]};
      return {w2, w1, w0};
   endfunction

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [95:0] e);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; {wr_w2, wr_w1, wr_w0} = e;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_lookup(input logic [59:0] k, input logic [1:0] alg);
      @(negedge clk);
      req_valid = 1'b1; req_key = k; alg_sel = alg;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_miss(input string rq);
      chk(rq, {rsp_valid, rsp_hit}, 2'b10);
      chk(rq, {rsp_addr, rsp_dest, rsp_pmask, rsp_age, rsp_mcast, rsp_trunk, rsp_static}, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [59:0] k;
      logic [AW-1:0] a;
      vec_t v;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset", {rsp_valid, rsp_hit}, 2'b00);
      rst_n = 1'b1;
      do_lookup(VECS[0].key, 2'b00);
      chk_miss("R11 empty table");

      // table walk: R1 R2 R3 R4 R5 R7 R8
      for (int i = 0; i < 6; i++) begin
         a = ref_addr(VECS[i].alg, VECS[i].half, VECS[i].key, VECS[i].way);
         do_write(a, mk_entry(VECS[i], 1'b1));
         do_lookup(VECS[i].key, VECS[i].alg);
         chk("R1 R2 R3 hit", {rsp_valid, rsp_hit}, 2'b11);
         chk("R4 half/way", {rsp_half, rsp_way}, {VECS[i].half, VECS[i].way});
         chk("R4 address", rsp_addr, a);
         chk("R8 mcast flag", rsp_mcast, VECS[i].mc);
         chk("R7 unicast fields", {rsp_dest, rsp_trunk, rsp_static, rsp_age},
             {VECS[i].dest, VECS[i].trunk, VECS[i].stat, VECS[i].age});
         chk("R8 pmask", rsp_pmask, VECS[i].pmask);
      end

      // R3: row 1 sits in half 0 under algorithm 1; look up with algorithm 0
      a = ref_addr(2'b00, 1'b0, VECS[1].key, 2'd3);
      do_lookup(VECS[1].key, 2'b00);
      chk("R3 alg_sel[0] changes bucket", rsp_hit,
          (a == ref_addr(2'b01, 1'b0, VECS[1].key, 2'd3)));

      // R5: VLAN ID mismatch
      k = VECS[0].key ^ 60'h1;
      do_lookup(k, 2'b00);
      chk_miss("R5 vid mismatch");

      // R5: valid bit clear
      v = VECS[0];
      v.key = 60'h0A0B0C0D0E0F_123;
      do_write(ref_addr(2'b00, 1'b0, v.key, 2'd1), mk_entry(v, 1'b0));
      do_lookup(v.key, 2'b00);
      chk_miss("R5 invalid entry");

      // R6: priority half 0 over half 1, lowest way
      v.key = 60'h02FEED000042_00C;
      do_write(ref_addr(2'b00, 1'b1, v.key, 2'd0), mk_entry(v, 1'b1));
      do_write(ref_addr(2'b00, 1'b0, v.key, 2'd2), mk_entry(v, 1'b1));
      do_lookup(v.key, 2'b00);
      chk("R6 half0 beats half1", {rsp_hit, rsp_half, rsp_way}, {1'b1, 1'b0, 2'd2});
      do_write(ref_addr(2'b00, 1'b0, v.key, 2'd1), mk_entry(v, 1'b1));
      do_lookup(v.key, 2'b00);
      chk("R6 lowest way", {rsp_hit, rsp_half, rsp_way}, {1'b1, 1'b0, 2'd1});

      // R9: latency and pulse width
      @(negedge clk);
      req_valid = 1'b1; req_key = VECS[0].key; alg_sel = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 not yet valid", rsp_valid, 1'b0);
      @(negedge clk);
      chk("R9 valid on second edge", {rsp_valid, rsp_hit}, 2'b11);
      @(negedge clk);
      chk("R9 single pulse", rsp_valid, 1'b0);

      // R10: write in the request cycle is seen
      v.key = 60'h0266778899AA_321;
      a = ref_addr(2'b00, 1'b0, v.key, 2'd0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; {wr_w2, wr_w1, wr_w0} = mk_entry(v, 1'b1);
      req_valid = 1'b1; req_key = v.key; alg_sel = 2'b00;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      @(negedge clk);
      chk("R10 same-cycle write visible", {rsp_valid, rsp_hit}, 2'b11);

      // R10: write one cycle after the request is not seen
      v.key = 60'h02BBCCDDEEFF_456;
      a = ref_addr(2'b00, 1'b0, v.key, 2'd0);
      @(negedge clk);
      req_valid = 1'b1; req_key = v.key; alg_sel = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      wr_en = 1'b1; wr_addr = a; {wr_w2, wr_w1, wr_w0} = mk_entry(v, 1'b1);
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 late write unseen", {rsp_valid, rsp_hit}, 2'b10);
      do_lookup(v.key, 2'b00);
      chk("R10 late write lands", {rsp_valid, rsp_hit}, 2'b11);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule